// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-way interrupt controller. Each request line is latched into a pending register. A per-line trigger setting decides how: a level line copies its input every cycle, and an edge line latches a low-to-high transition and holds it until it is serviced. Pending lines are filtered by a mask register and ranked by a priority scheme whose starting point rotates. The best candidate is then compared against the lines already being serviced, so a request is raised only when it would genuinely preempt the current work.

The surrounding controller drives decoded strobes into the core: an acknowledge for the presented line, end-of-service commands (non-specific or named, each with an optional rotation), and a set-base command. Writes to the mask, the trigger setting and the auto end-of-service mode arrive through separate write enables. The core answers with an interrupt flag and the winning line number. All state updates on one rising clock edge. The ranking logic is purely combinational over that state.

Top module: `irq_resolver`

## Requirements
- R1: A line whose trigger bit is 1 (level mode) has its pending bit equal to the input as sampled at the previous clock edge, so it rises and falls with the input one cycle later.
- R2: A line whose trigger bit is 0 (edge mode) becomes pending at the edge where the input is high and was low at the previous edge; a later fall of the input does not clear it.
- R3: The rank of line i is (i − base) mod 8, with rank 0 the best; base resets to 0, so line 0 then beats every other line.
- R4: irq_o is 1 exactly when the best-ranked pending, unmasked line ranks strictly better than the best-ranked line in service; irq_line_o then carries that line, else 0. Masked lines stay pending and appear once unmasked.
- R5: ack_i while irq_o is 1 with auto mode off marks the presented line in service; ack_i while irq_o is 0 changes nothing.
- R6: An accepted ack clears the pending bit of an edge-mode line, even when a new rising edge arrives in the same cycle, and leaves a level-mode pending bit untouched.
- R7: With auto mode on, an accepted ack marks nothing in service; if auto rotation is also on, base becomes (acked line + 1) mod 8.
- R8: cmd_op_i = 0 clears the best-ranked in-service bit; cmd_op_i = 1 does the same and sets base to that line + 1 (mod 8); with nothing in service both leave base and state unchanged.
- R9: cmd_op_i = 2 clears the in-service bit of cmd_line_i; cmd_op_i = 3 also sets base to cmd_line_i + 1 (mod 8).
- R10: cmd_op_i = 4 sets base to cmd_line_i + 1 (mod 8), making cmd_line_i the lowest-ranked line; base 7 + 1 wraps to 0. Codes 5 to 7 do nothing.
- R11: Reset (rst_ni low) clears the pending, mask, in-service, trigger and previous-level state, the base and both mode flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NUM_LINES | Raw request inputs |
| trig_we_i | input | 1 | Write strobe for trigger settings |
| trig_level_i | input | NUM_LINES | Trigger setting per line, 1 = level |
| mask_we_i | input | 1 | Write strobe for mask |
| mask_i | input | NUM_LINES | Mask value, 1 = blocked |
| mode_we_i | input | 1 | Write strobe for mode flags |
| auto_eoi_i | input | 1 | Auto end-of-service mode |
| rot_auto_eoi_i | input | 1 | Rotate base on auto end-of-service |
| ack_i | input | 1 | Acknowledge of the presented line |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_line_i | input | LINE_W | Line operand of the command |
| irq_o | output | 1 | Interrupt pending toward the processor |
| irq_line_o | output | LINE_W | Winning line number |

## Verification
The bench builds the block with its default of eight lines, where the base is three bits wide. This makes the wrap of base from 7 to 0 reachable, as well as cases where the rotated order reverses the natural order. Three-line auto-rotate sequences walk the base across several positions. The test with simultaneous ack and edge checks that the acknowledge wins at the exact cycle where both touch the same line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    CMD_EOI          = 3'd0,
    CMD_ROT_EOI      = 3'd1,
    CMD_SPEC_EOI     = 3'd2,
    CMD_ROT_SPEC_EOI = 3'd3,
    CMD_SET_BASE     = 3'd4
  } cmd_op_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [NUM_LINES-1:0] level_mode_i,
  input  logic [NUM_LINES-1:0] ack_clr_i,
  output logic [NUM_LINES-1:0] req_o
);
  logic [NUM_LINES-1:0] prev_q, req_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic req_d;
    always_comb begin
      if (level_mode_i[i]) req_d = lines_i[i];
      else req_d = (req_q[i] | (lines_i[i] & ~prev_q[i])) & ~ack_clr_i[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        req_q[i]  <= req_d;
        prev_q[i] <= lines_i[i];
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_rot_enc.sv
module irq_rot_enc #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] vec_i,
  input  logic [LINE_W-1:0]    base_i,
  output logic                 found_o,
  output logic [LINE_W-1:0]    prio_o,
  output logic [LINE_W-1:0]    line_o
);
  logic [NUM_LINES-1:0] rot;

  // rot[k] holds the line whose rank is k
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_rot
    assign rot[k] = vec_i[LINE_W'(k) + base_i];
  end

  always_comb begin
    prio_o = '0;
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      if (rot[k]) prio_o = LINE_W'(k);
    end
  end

  assign found_o = |rot;
  assign line_o  = prio_o + base_i;
endmodule

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec
  import irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [LINE_W-1:0]    cmd_line_i,
  input  logic                 isr_found_i,
  input  logic [LINE_W-1:0]    isr_line_i,
  output logic [NUM_LINES-1:0] clr_o,
  output logic                 base_we_o,
  output logic [LINE_W-1:0]    base_o
);
  localparam logic [NUM_LINES-1:0] One = NUM_LINES'(1);

  always_comb begin
    clr_o     = '0;
    base_we_o = 1'b0;
    base_o    = '0;
    if (cmd_valid_i) begin
      case (cmd_op_e'(cmd_op_i))
        CMD_EOI: if (isr_found_i) clr_o = One << isr_line_i;
        CMD_ROT_EOI: if (isr_found_i) begin
          clr_o     = One << isr_line_i;
          base_we_o = 1'b1;
          base_o    = isr_line_i + 1'b1;
        end
        CMD_SPEC_EOI: clr_o = One << cmd_line_i;
        CMD_ROT_SPEC_EOI: begin
          clr_o     = One << cmd_line_i;
          base_we_o = 1'b1;
          base_o    = cmd_line_i + 1'b1;
        end
        CMD_SET_BASE: begin
          base_we_o = 1'b1;
          base_o    = cmd_line_i + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 trig_we_i,
  input  logic [NUM_LINES-1:0] trig_level_i,
  input  logic                 mask_we_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 mode_we_i,
  input  logic                 auto_eoi_i,
  input  logic                 rot_auto_eoi_i,
  input  logic                 ack_i,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [LINE_W-1:0]    cmd_line_i,
  output logic                 irq_o,
  output logic [LINE_W-1:0]    irq_line_o
);
  localparam logic [NUM_LINES-1:0] One = NUM_LINES'(1);

  logic [NUM_LINES-1:0] req_q, mask_q, isr_q, level_q;
  logic [LINE_W-1:0]    base_q;
  logic                 aeoi_q, rot_aeoi_q;

  logic                 req_found, isr_found;
  logic [LINE_W-1:0]    req_prio, isr_prio, req_line, isr_line;
  logic                 ack_fire;
  logic [NUM_LINES-1:0] ack_vec, cmd_clr;
  logic                 cmd_base_we;
  logic [LINE_W-1:0]    cmd_base;

  irq_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lines_i      (irq_lines_i),
    .level_mode_i (level_q),
    .ack_clr_i    (ack_vec & ~level_q),
    .req_o        (req_q)
  );

  irq_rot_enc #(.NUM_LINES(NUM_LINES)) u_req_enc (
    .vec_i   (req_q & ~mask_q),
    .base_i  (base_q),
    .found_o (req_found),
    .prio_o  (req_prio),
    .line_o  (req_line)
  );

  irq_rot_enc #(.NUM_LINES(NUM_LINES)) u_isr_enc (
    .vec_i   (isr_q),
    .base_i  (base_q),
    .found_o (isr_found),
    .prio_o  (isr_prio),
    .line_o  (isr_line)
  );

  irq_cmd_dec #(.NUM_LINES(NUM_LINES)) u_cmd_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_line_i  (cmd_line_i),
    .isr_found_i (isr_found),
    .isr_line_i  (isr_line),
    .clr_o       (cmd_clr),
    .base_we_o   (cmd_base_we),
    .base_o      (cmd_base)
  );

  assign irq_o      = req_found && (!isr_found || (req_prio < isr_prio));
  assign irq_line_o = irq_o ? req_line : '0;
  assign ack_fire   = ack_i && irq_o;
  assign ack_vec    = ack_fire ? (One << req_line) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      level_q    <= '0;
      isr_q      <= '0;
      base_q     <= '0;
      aeoi_q     <= 1'b0;
      rot_aeoi_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      if (trig_we_i) level_q <= trig_level_i;
      if (mode_we_i) begin
        aeoi_q     <= auto_eoi_i;
        rot_aeoi_q <= rot_auto_eoi_i;
      end
      isr_q <= (isr_q & ~cmd_clr) | (aeoi_q ? '0 : ack_vec);
      // a command base write wins over an auto rotation in the same cycle
      if (cmd_base_we) base_q <= cmd_base;
      else if (ack_fire && aeoi_q && rot_aeoi_q) base_q <= req_line + 1'b1;
    end
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_lines_i,
  input logic                 trig_we_i,
  input logic                 ack_i,
  input logic                 cmd_valid_i,
  input logic                 irq_o,
  input logic [LINE_W-1:0]    irq_line_o,
  input logic [NUM_LINES-1:0] req_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] isr_q,
  input logic [NUM_LINES-1:0] level_q,
  input logic                 aeoi_q
);
  a_r1_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_we_i |=> (((req_q ^ $past(irq_lines_i)) & $past(level_q)) == '0));

  a_r2_edge_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_we_i |=> ((req_q & ~$past(req_q) & ~$past(level_q) & ~$past(irq_lines_i)) == '0));

  a_r4_line_pending_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req_q[irq_line_o] && !mask_q[irq_line_o]));

  a_r4_line_not_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !isr_q[irq_line_o]);

  a_r5_ack_marks_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !aeoi_q && !cmd_valid_i) |=> isr_q[$past(irq_line_o)]);

  a_r7_auto_keeps_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi_q && !cmd_valid_i) |=> (isr_q == $past(isr_q)));
endmodule

bind irq_resolver irq_resolver_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_lines_i (irq_lines_i),
  .trig_we_i   (trig_we_i),
  .ack_i       (ack_i),
  .cmd_valid_i (cmd_valid_i),
  .irq_o       (irq_o),
  .irq_line_o  (irq_line_o),
  .req_q       (req_q),
  .mask_q      (mask_q),
  .isr_q       (isr_q),
  .level_q     (level_q),
  .aeoi_q      (aeoi_q)
);

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] lines = '0;
  logic trig_we = 1'b0;
  logic [N-1:0] trig_level = '0;
  logic mask_we = 1'b0;
  logic [N-1:0] mask = '0;
  logic mode_we = 1'b0;
  logic aeoi = 1'b0, rot_aeoi = 1'b0;
  logic ack = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_line = '0;
  logic irq;
  logic [2:0] irq_line;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_resolver #(.NUM_LINES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(lines),
    .trig_we_i(trig_we), .trig_level_i(trig_level),
    .mask_we_i(mask_we), .mask_i(mask),
    .mode_we_i(mode_we), .auto_eoi_i(aeoi), .rot_auto_eoi_i(rot_aeoi),
    .ack_i(ack), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_line_i(cmd_line),
    .irq_o(irq), .irq_line_o(irq_line)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_irq(string req, logic exp_irq, logic [2:0] exp_line);
    tests++;
    if (irq !== exp_irq || irq_line !== exp_line) begin
      fails++;
      $display("FAIL %s: irq=%0b line=%0d expected irq=%0b line=%0d",
               req, irq, irq_line, exp_irq, exp_line);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic send_cmd(logic [2:0] op, logic [2:0] ln);
    cmd_valid = 1'b1; cmd_op = op; cmd_line = ln;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic set_lines(logic [N-1:0] v);
    lines = v; step();
  endtask

  task automatic write_mask(logic [N-1:0] v);
    mask_we = 1'b1; mask = v; step(); mask_we = 1'b0;
  endtask

  task automatic write_trig(logic [N-1:0] v);
    trig_we = 1'b1; trig_level = v; step(); trig_we = 1'b0;
  endtask

  task automatic write_mode(logic a, logic r);
    mode_we = 1'b1; aeoi = a; rot_aeoi = r; step(); mode_we = 1'b0;
  endtask

  task automatic t_edge_nesting();
    set_lines(8'h08); expect_irq("R2 edge capture", 1, 3);
    set_lines(8'h00); expect_irq("R2 held after fall", 1, 3);
    pulse_ack();      expect_irq("R5 ack enters service", 0, 0);
    set_lines(8'h20); expect_irq("R4 lower rank blocked", 0, 0);
    set_lines(8'h22); expect_irq("R4 higher rank preempts", 1, 1);
    pulse_ack();      expect_irq("R5 nested ack", 0, 0);
    send_cmd(3'd0, 3'd0); expect_irq("R8 eoi clears best (line1)", 0, 0);
    send_cmd(3'd0, 3'd0); expect_irq("R8 eoi clears next (line3)", 1, 5);
    pulse_ack(); send_cmd(3'd0, 3'd0);
    set_lines(8'h00); expect_irq("R8 idle after cleanup", 0, 0);
  endtask

  task automatic t_level();
    write_trig(8'h10);
    set_lines(8'h10); expect_irq("R1 level capture", 1, 4);
    pulse_ack();      expect_irq("R5 level ack", 0, 0);
    send_cmd(3'd2, 3'd4); expect_irq("R6 level request kept by ack", 1, 4);
    set_lines(8'h00); expect_irq("R1 level follows low", 0, 0);
    write_trig(8'h00);
  endtask

  task automatic t_ack_idle();
    pulse_ack();
    set_lines(8'h01); expect_irq("R5 idle ack ignored", 1, 0);
    pulse_ack(); send_cmd(3'd0, 3'd0);
    set_lines(8'h00); expect_irq("R5 cleanup", 0, 0);
  endtask

  task automatic t_mask();
    write_mask(8'h04);
    set_lines(8'h04); expect_irq("R4 masked line hidden", 0, 0);
    set_lines(8'h44); expect_irq("R4 unmasked line shown", 1, 6);
    write_mask(8'h00); expect_irq("R4 masked request kept pending", 1, 2);
    pulse_ack();      expect_irq("R4 in service blocks line6", 0, 0);
    send_cmd(3'd2, 3'd2); expect_irq("R9 specific eoi", 1, 6);
    pulse_ack(); send_cmd(3'd2, 3'd6);
    set_lines(8'h00); expect_irq("R9 cleanup", 0, 0);
  endtask

  task automatic t_rotation();
    send_cmd(3'd4, 3'd4);
    set_lines(8'h41); expect_irq("R10 set base makes line6 win", 1, 6);
    pulse_ack();      expect_irq("R3 line0 ranks below line6", 0, 0);
    send_cmd(3'd3, 3'd6); expect_irq("R9 rotating specific eoi", 1, 0);
    pulse_ack();
    send_cmd(3'd1, 3'd0); expect_irq("R8 rotating eoi clears", 0, 0);
    set_lines(8'h00);
    set_lines(8'h81); expect_irq("R8 base moved past line0", 1, 7);
    pulse_ack();      expect_irq("R3 line0 lowest", 0, 0);
    send_cmd(3'd2, 3'd7); expect_irq("R9 plain specific eoi", 1, 0);
    pulse_ack(); send_cmd(3'd0, 3'd0);
    set_lines(8'h00);
    send_cmd(3'd4, 3'd7);
    set_lines(8'h81); expect_irq("R10 base wraps to 0", 1, 0);
    pulse_ack(); send_cmd(3'd0, 3'd0); expect_irq("R3 line7 next", 1, 7);
    pulse_ack(); send_cmd(3'd0, 3'd0);
    set_lines(8'h00); expect_irq("R10 cleanup", 0, 0);
  endtask

  task automatic t_empty_eoi();
    send_cmd(3'd1, 3'd5);
    set_lines(8'h03); expect_irq("R8 empty rotating eoi keeps base", 1, 0);
    pulse_ack(); send_cmd(3'd0, 3'd0); expect_irq("R8 next line", 1, 1);
    pulse_ack(); send_cmd(3'd0, 3'd0);
    set_lines(8'h00); expect_irq("R8 cleanup", 0, 0);
  endtask

  task automatic t_auto();
    write_mode(1'b1, 1'b0);
    set_lines(8'h24); expect_irq("R7 auto first", 1, 2);
    pulse_ack();      expect_irq("R7 auto no service bit", 1, 5);
    pulse_ack();      expect_irq("R7 auto drained", 0, 0);
    set_lines(8'h00);
    set_lines(8'h04); expect_irq("R6 new edge", 1, 2);
    set_lines(8'h00); expect_irq("R6 still pending", 1, 2);
    ack = 1'b1; lines = 8'h04; step(); ack = 1'b0;
    expect_irq("R6 ack beats same-cycle edge", 0, 0);
    set_lines(8'h00);
    write_mode(1'b1, 1'b1);
    set_lines(8'h0B); expect_irq("R7 rotate start", 1, 0);
    pulse_ack();      expect_irq("R7 rotate base1", 1, 1);
    pulse_ack();      expect_irq("R7 rotate base2", 1, 3);
    pulse_ack();      expect_irq("R7 rotate drained", 0, 0);
    set_lines(8'h00);
    set_lines(8'h09); expect_irq("R7 base4 ranks line0 over line3", 1, 0);
    pulse_ack();      expect_irq("R7 then line3", 1, 3);
    pulse_ack();
    set_lines(8'h00);
    write_mode(1'b0, 1'b0);
    send_cmd(3'd4, 3'd7);
  endtask

  task automatic t_reset();
    write_mask(8'hFF);
    set_lines(8'h01); expect_irq("R11 masked before reset", 0, 0);
    rst_ni = 1'b0; step(); expect_irq("R11 in reset", 0, 0);
    rst_ni = 1'b1; step(); expect_irq("R11 mask cleared", 1, 0);
    set_lines(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    expect_irq("R11 reset state", 0, 0);
    t_edge_nesting();
    t_level();
    t_ack_idle();
    t_mask();
    t_rotation();
    t_empty_eoi();
    t_auto();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule